// File: doc/BRIEF.md
# Stack-Frame Indirect Indexed Address Generator

This block forms effective addresses for an addressing mode that locates a 16-bit pointer inside the hardware stack frame. An 8-bit offset taken from the instruction is added to the stack pointer. The sum selects the frame slot, and the pointer is read from that slot in the stack page. The 8-bit Y index is then added to the pointer to give the effective address. That address then serves a data load, a data store or an indirect subroutine jump.

The sequencer reads the pointer high byte first and the low byte second. The frame index is held in one temporary register until the low-byte read, and the low byte then overwrites it. No separate index register is needed. Memory is read combinationally: the byte at `mem_addr_o` is valid on `mem_rdata_i` in the same cycle that `mem_rd_o` is high. Stepping Y over successive operations walks a table whose base pointer sits on the stack.

Top module: `sri_agen`

## Requirements
- R1: After reset, `busy_o`, `mem_rd_o` and `ea_valid_o` are low.
- R2: In the first cycle after `start_i` is accepted in idle, `mem_rd_o` is high and `mem_addr_o` = 16'h0100 + ((S + off + 1) mod 256). This is the pointer high byte.
- R3: In the second cycle after acceptance, `mem_rd_o` is high and `mem_addr_o` = 16'h0100 + ((S + off) mod 256). This is the pointer low byte.
- R4: In the third cycle after acceptance, `ea_valid_o` is high for exactly one cycle and `ea_o` = ({high, low} + Y) mod 65536.
- R5: `start_i` is ignored while `busy_o` is high. The running operation completes unchanged, and the block returns to idle with no further reads.
- R6: During the valid cycle, `kind_o` equals the `kind_i` captured at acceptance. The encoding is 0 = load, 1 = store and 2 = jump.
- R7: S, offset and Y are captured at acceptance. Changes on those inputs afterwards do not alter the addresses or the result.
- R8: `mem_rd_o` is high only in the two fetch cycles of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation |
| kind_i | input | 2 | Access kind: 0 load, 1 store, 2 jump |
| sp_i | input | 8 | Stack pointer |
| off_i | input | 8 | Instruction frame offset |
| y_i | input | 8 | Y index |
| mem_rdata_i | input | 8 | Byte read from `mem_addr_o` |
| mem_addr_o | output | 16 | Frame byte address |
| mem_rd_o | output | 1 | Read strobe |
| busy_o | output | 1 | Operation in progress |
| ea_o | output | 16 | Effective address |
| ea_valid_o | output | 1 | Effective address is ready |
| kind_o | output | 2 | Kind of the access being completed |

## Verification
Some properties are checked on every cycle. Reads occur only while busy and always fall in the stack page. The low-byte read sits one byte below the high-byte read of the cycle before. The valid strobe lasts one cycle and follows a read, and the kind stays steady through an operation. Other behaviours need the bench's sweeps over stack pointer, offset, Y and pointer values: the exact frame addresses with page wrap, the modulo-65536 sum, the capture of inputs and the dropping of a start issued while busy.

// File: rtl/sri_pkg.sv
package sri_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_JUMP  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_DONE = 2'd3
  } agen_state_e;
endpackage

// File: rtl/sri_frame_addr.sv
module sri_frame_addr #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-DATA_W-1:0] PAGE = 1
) (
  input  logic [DATA_W-1:0] idx_i,
  input  logic              sel_hi_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [DATA_W-1:0] slot;
  // wraps inside the stack page
  assign slot   = idx_i + DATA_W'(sel_hi_i);
  assign addr_o = {PAGE, slot};
endmodule

// File: rtl/sri_index_add.sv
module sri_index_add #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] idx_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int EXT_W = ADDR_W - DATA_W;
  assign sum_o = base_i + {{EXT_W{1'b0}}, idx_i};
endmodule

// File: rtl/sri_agen_fsm.sv
module sri_agen_fsm
  import sri_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output agen_state_e state_o,
  output logic        accept_o,
  output logic        busy_o,
  output logic        rd_o,
  output logic        sel_hi_o,
  output logic        valid_o
);
  agen_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_HI;
      ST_HI:   state_d = ST_LO;
      ST_LO:   state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign busy_o   = (state_q != ST_IDLE);
  assign rd_o     = (state_q == ST_HI) || (state_q == ST_LO);
  assign sel_hi_o = (state_q == ST_HI);
  assign valid_o  = (state_q == ST_DONE);
endmodule

// File: rtl/sri_agen.sv
module sri_agen
  import sri_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-DATA_W-1:0] PAGE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] off_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_valid_o,
  output logic [1:0]        kind_o
);
  agen_state_e state;
  logic accept, sel_hi;

  logic [DATA_W-1:0] tmp_q;   // frame index, then pointer low byte
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] y_q;
  acc_kind_e         kind_q;
  logic [ADDR_W-1:0] ptr;

  sri_agen_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .state_o  (state),
    .accept_o (accept),
    .busy_o   (busy_o),
    .rd_o     (mem_rd_o),
    .sel_hi_o (sel_hi),
    .valid_o  (ea_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q  <= '0;
      hi_q   <= '0;
      y_q    <= '0;
      kind_q <= ACC_LOAD;
    end else begin
      if (accept) begin
        tmp_q  <= sp_i + off_i;
        y_q    <= y_i;
        kind_q <= acc_kind_e'(kind_i);
      end
      if (state == ST_HI) hi_q  <= mem_rdata_i;
      if (state == ST_LO) tmp_q <= mem_rdata_i;
    end
  end

  sri_frame_addr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE(PAGE)) u_frame (
    .idx_i    (tmp_q),
    .sel_hi_i (sel_hi),
    .addr_o   (mem_addr_o)
  );

  assign ptr = ADDR_W'({hi_q, tmp_q});

  sri_index_add #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_add (
    .base_i (ptr),
    .idx_i  (y_q),
    .sum_o  (ea_o)
  );

  assign kind_o = kind_q;
endmodule

// File: rtl/sri_agen_chk.sv
module sri_agen_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-DATA_W-1:0] PAGE = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              busy_o,
  input logic              ea_valid_o,
  input logic [1:0]        kind_o
);
  assert_rd_only_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);
  assert_start_reads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> mem_rd_o);
  assert_read_in_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (mem_addr_o[ADDR_W-1:DATA_W] == PAGE));
  assert_low_below_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && busy_o) |=> (mem_rd_o |->
      (mem_addr_o[DATA_W-1:0] == DATA_W'($past(mem_addr_o[DATA_W-1:0]) - 1'b1))));
  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ea_valid_o |=> !ea_valid_o);
  assert_valid_after_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (ea_valid_o || mem_rd_o));
  assert_kind_steady_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_rd_o) |=> $stable(kind_o));
endmodule

bind sri_agen sri_agen_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE(PAGE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .busy_o     (busy_o),
  .ea_valid_o (ea_valid_o),
  .kind_o     (kind_o)
);

// File: tb/sri_agen_bench.sv
module sri_agen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [7:0] sp = 8'd0, off = 8'd0, y = 8'd0;
  logic [7:0] rdata;
  logic [15:0] addr, ea;
  logic rd, busy, valid;
  logic [1:0] kind_out;
  logic [7:0] page_mem [256];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign rdata = page_mem[addr[7:0]];

  sri_agen u_sri_agen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind),
    .sp_i(sp), .off_i(off), .y_i(y), .mem_rdata_i(rdata),
    .mem_addr_o(addr), .mem_rd_o(rd), .busy_o(busy),
    .ea_o(ea), .ea_valid_o(valid), .kind_o(kind_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] s_v, input logic [7:0] o_v, input logic [7:0] y_v,
                        input logic [15:0] ptr, input logic [1:0] k_v, input bit poke);
    logic [7:0] idx;
    logic [15:0] exp_ea;
    idx = s_v + o_v;
    page_mem[idx] = ptr[7:0];
    page_mem[8'(idx + 8'd1)] = ptr[15:8];
    exp_ea = ptr + {8'h00, y_v};
    @(negedge clk);
    start = 1'b1; sp = s_v; off = o_v; y = y_v; kind = k_v;
    @(negedge clk);
    // R7: scramble captured inputs
    start = poke; sp = ~s_v; off = o_v ^ 8'h5a; y = ~y_v; kind = 2'd3 - k_v;
    chk(rd === 1'b1, "R2 rd", 32'(rd), 1);
    chk(addr === {8'h01, 8'(idx + 8'd1)}, "R2 hi addr", 32'(addr), 32'({8'h01, 8'(idx + 8'd1)}));
    @(negedge clk);
    start = 1'b0;
    chk(rd === 1'b1 && addr === {8'h01, idx}, "R3 lo addr", 32'(addr), 32'({8'h01, idx}));
    @(negedge clk);
    chk(valid === 1'b1 && rd === 1'b0, "R4 valid", 32'({valid, rd}), 32'h2);
    chk(ea === exp_ea, "R4 R7 ea", 32'(ea), 32'(exp_ea));
    chk(kind_out === k_v, "R6 kind", 32'(kind_out), 32'(k_v));
    @(negedge clk);
    chk(valid === 1'b0, "R4 one cycle", 32'(valid), 0);
    if (poke) chk(busy === 1'b0 && rd === 1'b0, "R5 start ignored", 32'({busy, rd}), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) page_mem[i] = 8'(i * 37 + 11);
    #25;
    chk(busy === 1'b0 && rd === 1'b0 && valid === 1'b0, "R1 reset", 32'({busy, rd, valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && rd === 1'b0, "R1 R8 idle", 32'({busy, rd}), 0);
    // wrap corners
    run_op(8'hff, 8'h00, 8'h01, 16'hffff, 2'd0, 1'b0);
    run_op(8'hfe, 8'h01, 8'hff, 16'hff80, 2'd2, 1'b1);
    run_op(8'h80, 8'h80, 8'h00, 16'h1234, 2'd1, 1'b0);
    // table walk with stepping Y
    for (int j = 0; j < 16; j++) run_op(8'hf0, 8'h03, 8'(j * 2), 16'h4000, 2'd0, 1'b0);
    // sweep
    for (int s = 0; s < 256; s += 15)
      for (int oi = 0; oi < 6; oi++)
        for (int yi = 0; yi < 4; yi++) begin
          logic [7:0] o_v, y_v;
          logic [15:0] p;
          o_v = (oi == 0) ? 8'h00 : (oi == 1) ? 8'h01 : (oi == 2) ? 8'h7f :
                (oi == 3) ? 8'h80 : (oi == 4) ? 8'hfe : 8'hff;
          y_v = (yi == 0) ? 8'h00 : (yi == 1) ? 8'h01 : (yi == 2) ? 8'h80 : 8'hff;
          p = 16'((s * 257 + oi * 4099 + yi * 733) ^ 16'ha5c3);
          if ((s + oi) % 7 == 0) p = 16'hffff;
          run_op(8'(s), o_v, y_v, p, 2'(yi % 3), 1'((s + yi) % 2));
        end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=0 exp=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule